// File: doc/BRIEF.md
# Serial Register Write Port for an Audio Converter

This block is the slave side of a four-wire serial control link that loads the settings register file of a multichannel audio converter. A host lowers the select line, clocks bytes in on the data line and raises select to end the transaction. The first byte carries the device's 7-bit address and a direction bit. The second byte is a pointer byte holding a 4-bit register address and an auto-increment flag. Every byte after that is written to the register file.

The register file covers addresses 01h to 0Dh. Address 0Dh is a fixed revision code that cannot be written. Every register is driven onto one flat output vector, so the converter datapath can use the settings directly. The serial pins are brought into the system clock domain by two-stage synchronisers and are sampled there. The serial clock must therefore be several times slower than the system clock.

Top module: `spi_regport`

## Requirements
- R1: After reset every register holds its default: 09h at addresses 03h, 04h and 05h (a mixing code of 1001 in the low nibble, meaning plain stereo), the REV parameter (default 1) in the low nibble of 0Dh, and 00h everywhere else. `spi_mode` is 0.
- R2: `spi_mode` goes to 1 after the first high-to-low transition of `spi_cs_n` following reset and stays at 1 until the next reset.
- R3: The first byte of a transaction must equal 20h, which is address 0010000 followed by a write bit of 0. Any other first byte, including the read form 21h, causes every following byte to be ignored until `spi_cs_n` rises.
- R4: In the second byte, bit 7 is the auto-increment flag and bits 3:0 are the register address. Bits 6:4 have no effect.
- R5: With the auto-increment flag set, successive data bytes go to the pointer address, then the pointer plus 1, and so on. The 4-bit pointer wraps from 0Fh to 00h.
- R6: With the auto-increment flag clear, every data byte of the transaction goes to the same pointer address, and the last one remains.
- R7: Writes to address 0Dh and to the unmapped addresses 00h, 0Eh and 0Fh are discarded. A discarded write still advances the pointer when auto-increment is on.
- R8: A rising edge of `spi_cs_n` discards any partly received byte. The next transaction starts again with the address byte.
- R9: Data is taken MSB first, one bit on each rising edge of `spi_sck` while `spi_cs_n` is low.
- R10: The register at address a (1 to 13) appears on `reg_q[(a-1)*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_sck | input | 1 | Serial bit clock from the host |
| spi_sdi | input | 1 | Serial data from the host |
| spi_mode | output | 1 | Set once the serial control format has been selected |
| reg_q | output | NREG*8 | All registers, address 1 in the lowest byte |

## Verification
The assertions assume that the host holds each serial level for at least three system clocks. This keeps every synchronised edge distinct, so a completed byte never appears on two adjacent cycles and a write request always follows a byte by exactly one cycle. The bench drives each serial half period for six system clocks and lowers the bit clock before select rises. It also leaves select high for ten clocks between transactions, so every edge reaches the synchronisers cleanly.

// File: rtl/spirp_pkg.sv
package spirp_pkg;

  typedef enum logic [1:0] {
    ST_ADDR = 2'd0,
    ST_PTR  = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic       incr;
    logic [2:0] spare;
    logic [3:0] map;
  } ptr_byte_t;

  function automatic logic addr_match(input logic [7:0] b, input logic [6:0] dev);
    return b == {dev, 1'b0};
  endfunction

  function automatic ptr_byte_t ptr_decode(input logic [7:0] b);
    ptr_byte_t p;
    p.incr  = b[7];
    p.spare = b[6:4];
    p.map   = b[3:0];
    return p;
  endfunction

  function automatic logic [3:0] ptr_next(input logic [3:0] p, input logic incr);
    return incr ? p + 4'd1 : p;
  endfunction

  function automatic logic reg_writable(input logic [3:0] a, input int nreg);
    return (a != 4'd0) && (int'(a) < nreg);
  endfunction

  function automatic logic [7:0] reg_default(input int a, input int nreg, input logic [3:0] rev);
    if (a == nreg) return {4'h0, rev};
    if (a >= 3 && a <= 5) return 8'h09;
    return 8'h00;
  endfunction

endpackage

// File: rtl/spirp_sync.sv
module spirp_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) st[0] <= RST_VAL;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) st[i] <= RST_VAL;
      else        st[i] <= st[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_prev <= RST_VAL;
    else        q_prev <= st[STAGES-1];
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spirp_shifter.sv
module spirp_shifter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selected,
  input  logic              sck_rise,
  input  logic              sdi,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_q
);
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_q     <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (!selected) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[BYTE_W-3:0], sdi};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          byte_valid <= 1'b1;
          byte_q     <= {shreg, sdi};
        end
      end
    end
  end
endmodule

// File: rtl/spirp_seq.sv
module spirp_seq
  import spirp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       selected,
  input  logic       cs_fall,
  input  logic       byte_valid,
  input  logic [7:0] byte_q,
  output logic       spi_mode,
  output logic       wr_req,
  output logic [3:0] wr_addr,
  output logic [7:0] wr_data
);
  seq_state_t state;
  ptr_byte_t  pdec;
  logic [3:0] ptr;
  logic       incr;
  logic [2:0] spare_seen;

  assign pdec = ptr_decode(byte_q);

  always_ff @(posedge clk) begin
    if (!rst_n) spi_mode <= 1'b0;
    else if (cs_fall) spi_mode <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_ADDR;
      ptr        <= '0;
      incr       <= 1'b0;
      spare_seen <= '0;
      wr_req     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_req <= 1'b0;
      if (!selected) begin
        state <= ST_ADDR;
      end else if (byte_valid) begin
        unique case (state)
          ST_ADDR: state <= addr_match(byte_q, DEV_ADDR) ? ST_PTR : ST_SKIP;
          ST_PTR: begin
            ptr        <= pdec.map;
            incr       <= pdec.incr;
            spare_seen <= pdec.spare;
            state      <= ST_DATA;
          end
          ST_DATA: begin
            wr_req  <= 1'b1;
            wr_addr <= ptr;
            wr_data <= byte_q;
            ptr     <= ptr_next(ptr, incr);
          end
          ST_SKIP: state <= ST_SKIP;
        endcase
      end
    end
  end

  logic spare_unused;
  assign spare_unused = ^spare_seen;
endmodule

// File: rtl/spirp_regfile.sv
module spirp_regfile
  import spirp_pkg::*;
#(
  parameter int         NREG = 13,
  parameter logic [3:0] REV  = 4'h1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic [3:0]      wr_addr,
  input  logic [7:0]      wr_data,
  output logic            wr_commit,
  output logic [NREG*8-1:0] reg_q
);
  assign wr_commit = wr_req && reg_writable(wr_addr, NREG);

  for (genvar a = 1; a <= NREG; a++) begin : g_reg
    if (a == NREG) begin : g_ro
      assign reg_q[(a-1)*8 +: 8] = reg_default(a, NREG, REV);
    end else begin : g_rw
      logic [7:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= reg_default(a, NREG, REV);
        else if (wr_commit && wr_addr == 4'(a)) r <= wr_data;
      end
      assign reg_q[(a-1)*8 +: 8] = r;
    end
  end
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spirp_pkg::*;
#(
  parameter int         NREG     = 13,
  parameter logic [6:0] DEV_ADDR = 7'h10,
  parameter logic [3:0] REV      = 4'h1,
  parameter int         SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_sdi,
  output logic              spi_mode,
  output logic [NREG*8-1:0] reg_q
);
  logic [2:0] pins_q, pins_p;
  logic       selected, cs_fall, sck_rise;
  logic       byte_valid;
  logic [7:0] byte_q;
  logic       wr_req, wr_commit;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;

  spirp_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({spi_cs_n, spi_sck, spi_sdi}),
    .q(pins_q), .q_prev(pins_p)
  );

  assign selected = !pins_q[2];
  assign cs_fall  = pins_p[2] && !pins_q[2];
  assign sck_rise = !pins_p[1] && pins_q[1];

  spirp_shifter #(.BYTE_W(8)) shift_i (
    .clk(clk), .rst_n(rst_n), .selected(selected), .sck_rise(sck_rise),
    .sdi(pins_q[0]), .byte_valid(byte_valid), .byte_q(byte_q)
  );

  spirp_seq #(.DEV_ADDR(DEV_ADDR)) seq_i (
    .clk(clk), .rst_n(rst_n), .selected(selected), .cs_fall(cs_fall),
    .byte_valid(byte_valid), .byte_q(byte_q), .spi_mode(spi_mode),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  spirp_regfile #(.NREG(NREG), .REV(REV)) rf_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit), .reg_q(reg_q)
  );
endmodule

// File: rtl/spirp_checker.sv
module spirp_checker #(
  parameter int NREG = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_mode,
  input logic              byte_valid,
  input logic              wr_req,
  input logic              wr_commit,
  input logic [NREG*8-1:0] reg_q
);
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode); // R2

  AST_WRITE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> spi_mode); // R3

  AST_REQ_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $past(byte_valid)); // R5

  AST_REV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(reg_q[NREG*8-1 -: 8])); // R7

  AST_NO_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(reg_q)); // R7

  AST_BYTE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R9
endmodule

bind spi_regport spirp_checker #(.NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .byte_valid(byte_valid),
  .wr_req(wr_req), .wr_commit(wr_commit), .reg_q(reg_q)
);

// File: tb/spi_regport_tb.sv
module spi_regport_tb_top;
  localparam int NREG = 13;
  localparam int HALF = 6;

  typedef struct {
    int         addr;
    logic [7:0] val;
    string      req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sck = 0, sdi = 0;
  logic spi_mode;
  logic [NREG*8-1:0] reg_q;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t sb[$];
  logic [7:0] model [16];
  int m_idx;
  bit m_ok, m_inc;
  logic [3:0] m_ptr;

  always #4 clk = ~clk;

  spi_regport dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi),
    .spi_mode(spi_mode), .reg_q(reg_q)
  );

  task automatic check1(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_snapshot(input string req);
    for (int a = 1; a <= NREG; a++) sb.push_back('{a, model[a], req});
  endtask

  always begin
    @(negedge clk);
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check1($sformatf("%s R10 addr%0d", e.req, e.addr), reg_q[(e.addr-1)*8 +: 8], e.val);
    end
  end

  task automatic begin_txn();
    m_idx = 0; m_ok = 0;
    wait_clk(2); cs_n = 0; wait_clk(HALF);
  endtask

  task automatic shift_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck = 0; sdi = b[i]; wait_clk(HALF);
      sck = 1; wait_clk(HALF);
    end
    sck = 0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    shift_bits(b, 8);
    if (m_idx == 0) m_ok = (b == 8'h20);
    else if (m_ok && m_idx == 1) begin m_ptr = b[3:0]; m_inc = b[7]; end
    else if (m_ok) begin
      if (m_ptr >= 1 && m_ptr <= 12) model[m_ptr] = b;
      if (m_inc) m_ptr = m_ptr + 4'd1;
    end
    m_idx++;
  endtask

  task automatic end_txn(input string req);
    wait_clk(HALF); cs_n = 1; wait_clk(10);
    push_snapshot(req);
    wait_clk(2);
  endtask

  initial begin
    for (int a = 0; a < 16; a++) model[a] = 8'h00;
    model[3] = 8'h09; model[4] = 8'h09; model[5] = 8'h09; model[13] = 8'h01;
    wait_clk(5); rst_n = 1; wait_clk(3);
    push_snapshot("R1 reset");
    wait_clk(2);
    check1("R1 spi_mode reset", {7'd0, spi_mode}, 8'd0);

    // R5 R9: auto-increment burst with asymmetric patterns
    begin_txn(); put_byte(8'h20); put_byte(8'h81);
    put_byte(8'hA1); put_byte(8'h3C); put_byte(8'h5E); end_txn("R5 R9 burst");
    check1("R2 spi_mode after select", {7'd0, spi_mode}, 8'd1);

    // R6: no increment, last byte stays
    begin_txn(); put_byte(8'h20); put_byte(8'h06);
    put_byte(8'h11); put_byte(8'h22); put_byte(8'h33); end_txn("R6 fixed ptr");

    // R4: spare pointer bits set
    begin_txn(); put_byte(8'h20); put_byte(8'hF8);
    put_byte(8'h44); put_byte(8'h55); end_txn("R4 spare bits");

    // R3: wrong address and read form
    begin_txn(); put_byte(8'h22); put_byte(8'h81); put_byte(8'h99); end_txn("R3 bad addr");
    begin_txn(); put_byte(8'h21); put_byte(8'h87); put_byte(8'h77); end_txn("R3 read form");

    // R7: read-only target, then wrap through unmapped addresses
    begin_txn(); put_byte(8'h20); put_byte(8'h0D); put_byte(8'hFF); end_txn("R7 ro write");
    begin_txn(); put_byte(8'h20); put_byte(8'h8C);
    put_byte(8'h5A); put_byte(8'h6B); put_byte(8'h7C); put_byte(8'h8D);
    put_byte(8'h9E); put_byte(8'hAF); end_txn("R5 R7 wrap");

    // R8: abort mid address byte, then a fresh transaction
    begin_txn(); shift_bits(8'h20, 5); end_txn("R8 abort addr");
    begin_txn(); put_byte(8'h20); put_byte(8'h02); put_byte(8'hC3); end_txn("R8 fresh txn");
    // R8: abort mid data byte leaves target unchanged
    begin_txn(); put_byte(8'h20); put_byte(8'h04); shift_bits(8'hFF, 4); end_txn("R8 abort data");

    check1("R2 spi_mode sticky", {7'd0, spi_mode}, 8'd1);
    wait_clk(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule